// File: doc/BRIEF.md
# Input Pin Change-of-State Detector

This block monitors a small group of general-purpose input pins and records any pin whose level has changed. Each pin passes through a two-stage synchronizer and then a filter that runs on a prescaled sampling tick. A new level is accepted only when it is seen on two sampling ticks in a row. An accepted change sets a sticky per-pin change flag. The flags and the current synchronized pin levels form one readable status word. Software reads this word to find out which pins moved and where each pin stands now.

A per-pin enable mask selects which change events may set a shared input-change status bit. One interrupt mask bit then gates that status bit onto the interrupt line. A read strobe returns the word and clears all change flags and the shared status bit. The value seen in the read cycle is the value from before the clear. A change that is accepted in the same cycle as a read is kept, so it is not lost.

Top module: `input_change_detector`

## Requirements
- R1: After reset, the status word is all zero, the shared status bit is 0 and the interrupt line is 0. This assumes all pins are low during reset.
- R2: Bit i of the status word (i in 0..NPINS-1) gives the level of pin i after the two-flop synchronizer (1 = high). It changes two clock edges after the pin changes and is never latched by a read.
- R3: The change flag for pin i is bit NPINS+i of the status word (1 = change seen). A new pin level held for at least 2*PRESCALE+3 clocks sets that flag. A level pulse shorter than PRESCALE clocks sets no flag.
- R4: A change flag stays set until a read, even after the pin returns to its earlier level.
- R5: While the read strobe is high, the status word shows the flags as they were before the read. On the next clock edge all change flags and the shared status bit clear, unless R8 applies.
- R6: The shared status bit sets only when a flag is being set and the enable bit of that pin is 1 (enable bit i belongs to pin i). A flag whose enable bit is 0 has no effect. Turning on the enable of a flag that is already set does not set the status bit either.
- R7: The interrupt line is high exactly when the shared status bit is 1 and the interrupt mask bit is 1.
- R8: A change accepted in the same cycle as a read leaves its flag set, and also the shared status bit if that pin is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NPINS | Asynchronous general-purpose input pins |
| rd_i | input | 1 | Read strobe; clears flags and status on the following edge |
| chg_en_i | input | NPINS | Per-pin enable of the shared status bit |
| irq_mask_i | input | 1 | Gates the shared status bit onto the interrupt line |
| rdata_o | output | 2*NPINS | Status word: change flags in the upper half, live levels in the lower half |
| chg_status_o | output | 1 | Shared input-change status bit |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is R8, where a change is accepted in exactly the same cycle as a read. The internal sampling tick cannot be seen from outside, so the bench holds the read strobe high through the whole time a pin change can take to be accepted. It samples every cycle. The flag and the status bit must then each be high for exactly one cycle. If a read were allowed to win over the event, they would never appear at all. Glitch rejection is tested with pulses one clock shorter than the sampling period. Such a pulse can never be present on two sampling ticks.

// File: rtl/icd_pkg.sv
// Package: shared types for the input change detector.
// Assumes: nothing; holds only type definitions.
package icd_pkg;

    // Filter state: steady, or waiting for a second tick that confirms a new level
    typedef enum logic {
        FLT_STEADY  = 1'b0,
        FLT_PENDING = 1'b1
    } flt_state_t;

endpackage

// File: rtl/icd_prescaler.sv
// Module: icd_prescaler
// Makes a one-cycle sampling tick every PRESCALE clocks.
// Assumes: PRESCALE >= 2; synchronous active-low reset.
module icd_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    // Free-running count that wraps at PRESCALE-1
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (PRESCALE > 1) begin : g_tick_chk
            // Ticks never come back to back, so each filter sample is PRESCALE apart (R3)
            p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/icd_pin_filter.sv
// Module: icd_pin_filter
// Synchronizes one asynchronous pin and accepts a new level only when it is
// seen on two sampling ticks in a row. Gives a one-cycle change pulse when a
// level is accepted.
// Assumes: the pin is low during reset; tick_i is a one-cycle pulse.
module icd_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic level_o,
    output logic change_o
);
    logic                  meta_q;
    logic                  sync_q;
    logic                  stable_q;
    logic                  change_q;
    icd_pkg::flt_state_t   state_q;

    // Two-flop synchronizer for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // Confirm a new level on two consecutive ticks, then accept it and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            change_q <= 1'b0;
            state_q  <= icd_pkg::FLT_STEADY;
        end else begin
            change_q <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    icd_pkg::FLT_STEADY: begin
                        if (sync_q != stable_q) state_q <= icd_pkg::FLT_PENDING;
                    end
                    icd_pkg::FLT_PENDING: begin
                        if (sync_q != stable_q) begin
                            stable_q <= sync_q;
                            change_q <= 1'b1;
                        end
                        state_q <= icd_pkg::FLT_STEADY;
                    end
                    default: state_q <= icd_pkg::FLT_STEADY;
                endcase
            end
        end
    end

    assign level_o  = sync_q;
    assign change_o = change_q;

    // A change is accepted only on a sampling tick (R3)
    p_change_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        change_q |-> $past(tick_i));

    // Each accepted change really flips the filtered level (R3)
    p_change_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
        change_q |-> (stable_q != $past(stable_q)));
endmodule

// File: rtl/icd_flag_bank.sv
// Module: icd_flag_bank
// Holds the sticky per-pin change flags and the shared status bit. A read
// clears both on the next edge; a change arriving in the same cycle wins.
// Assumes: change_i pulses are one cycle wide.
module icd_flag_bank #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic [NPINS-1:0] change_i,
    input  logic [NPINS-1:0] en_i,
    output logic [NPINS-1:0] flags_o,
    output logic             status_o
);
    logic [NPINS-1:0] flags_q;
    logic [NPINS-1:0] flags_n;
    logic             status_q;
    logic             status_n;

    // Next flag and status values: new events set, a read clears the rest
    always_comb begin
        flags_n  = change_i | (flags_q & ~{NPINS{rd_i}});
        status_n = (|(change_i & en_i)) | (status_q & ~rd_i);
    end

    // Register the flags and the shared status bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q  <= '0;
            status_q <= 1'b0;
        end else begin
            flags_q  <= flags_n;
            status_q <= status_n;
        end
    end

    assign flags_o  = flags_q;
    assign status_o = status_q;

    // A read with no new event leaves nothing set (R5)
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (change_i == '0)) |=> ((flags_q == '0) && !status_q));

    // An event is never lost, even during a read (R8)
    p_event_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (change_i != '0) |=> ((flags_q & $past(change_i)) == $past(change_i)));

    // The status bit rises only because of an enabled event (R6)
    p_status_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(|(change_i & en_i)));
endmodule

// File: rtl/input_change_detector.sv
// Module: input_change_detector (top)
// Watches NPINS input pins and gives a status word of {change flags, live
// levels}, a shared status bit and a masked interrupt line.
// Assumes: pins are low during reset; PRESCALE >= 2.
module input_change_detector #(
    parameter int NPINS    = 4,
    parameter int PRESCALE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pins_i,
    input  logic               rd_i,
    input  logic [NPINS-1:0]   chg_en_i,
    input  logic               irq_mask_i,
    output logic [2*NPINS-1:0] rdata_o,
    output logic               chg_status_o,
    output logic               irq_o
);
    logic             tick;
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] change;
    logic [NPINS-1:0] flags;
    logic             status;

    icd_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            icd_pin_filter u_filter (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick),
                .pin_i    (pins_i[g]),
                .level_o  (level[g]),
                .change_o (change[g])
            );
        end
    endgenerate

    icd_flag_bank #(.NPINS(NPINS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .change_i (change),
        .en_i     (chg_en_i),
        .flags_o  (flags),
        .status_o (status)
    );

    // Status word and interrupt line are combinational views of the state
    always_comb begin
        rdata_o      = {flags, level};
        chg_status_o = status;
        irq_o        = status & irq_mask_i;
    end
endmodule

// File: tb/test_input_change_detector.sv
`timescale 1ns/1ps
module test_input_change_detector;
    localparam int NP = 4;
    localparam int P  = 4;
    localparam int SETTLE = 2 * P + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          rd = 1'b0;
    logic [NP-1:0] en = '0;
    logic          mask = 1'b0;
    logic [2*NP-1:0] rdata;
    logic          status;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    input_change_detector #(.NPINS(NP), .PRESCALE(P)) i_input_change_detector (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .rd_i(rd), .chg_en_i(en),
        .irq_mask_i(mask), .rdata_o(rdata), .chg_status_o(status), .irq_o(irq));

    // {pins, enable, mask, expected flags, expected status, expected irq}
    localparam logic [14:0] VEC [8] = '{
        {4'b0001, 4'b1111, 1'b1, 4'b0001, 1'b1, 1'b1},
        {4'b0011, 4'b0001, 1'b1, 4'b0010, 1'b0, 1'b0},
        {4'b0011, 4'b1111, 1'b1, 4'b0000, 1'b0, 1'b0},
        {4'b1100, 4'b0100, 1'b0, 4'b1111, 1'b1, 1'b0},
        {4'b1000, 4'b1000, 1'b1, 4'b0100, 1'b0, 1'b0},
        {4'b0111, 4'b0001, 1'b1, 4'b1111, 1'b1, 1'b1},
        {4'b0000, 4'b0000, 1'b1, 4'b0111, 1'b0, 1'b0},
        {4'b1010, 4'b0010, 1'b1, 4'b1010, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    initial begin
        wait_neg(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word", rdata, 8'h00);
        check("R1 status", status, 0);
        check("R1 irq", irq, 0);

        // Table of vectors (R3, R6, R7)
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pins = VEC[i][14:11];
            en   = VEC[i][10:7];
            mask = VEC[i][6];
            wait_neg(SETTLE);
            check("R3 word", rdata, {VEC[i][5:2], VEC[i][14:11]});
            check("R6 status", status, VEC[i][1]);
            check("R7 irq", irq, VEC[i][0]);
            do_read();
        end

        // Return to all low and clear
        pins = '0; en = '0; mask = 1'b0;
        wait_neg(SETTLE);
        do_read();
        check("R5 cleared", rdata, 8'h00);

        // R2: level after two edges, not after one
        pins = 4'b0100;
        @(negedge clk);
        check("R2 one edge", rdata[3:0], 4'b0000);
        @(negedge clk);
        check("R2 two edges", rdata[3:0], 4'b0100);
        wait_neg(SETTLE);
        do_read();
        check("R2 level kept after read", rdata[3:0], 4'b0100);
        pins = '0;
        wait_neg(SETTLE);
        do_read();

        // R3: glitches shorter than PRESCALE are rejected
        en = 4'b1111;
        for (int g = 0; g < 6; g++) begin
            pins = 4'b0001;
            wait_neg(P - 1);
            pins = 4'b0000;
            wait_neg(P + g);
        end
        wait_neg(SETTLE);
        check("R3 glitch flags", rdata[7:4], 4'b0000);
        check("R3 glitch status", status, 0);

        // R4: flag sticks after the pin returns
        pins = 4'b0010;
        wait_neg(SETTLE);
        pins = 4'b0000;
        wait_neg(SETTLE);
        check("R4 sticky", rdata[7:4], 4'b0010);

        // R5: read cycle shows old value, clear on next edge
        rd = 1'b1;
        #1;
        check("R5 during read", rdata[7:4], 4'b0010);
        check("R5 status during read", status, 1);
        @(negedge clk) rd = 1'b0;
        check("R5 after read flags", rdata[7:4], 4'b0000);
        check("R5 after read status", status, 0);

        // R6: enabling an already-set flag does not set status
        en = 4'b0000;
        pins = 4'b1000;
        wait_neg(SETTLE);
        check("R6 disabled flag", rdata[7:4], 4'b1000);
        check("R6 disabled status", status, 0);
        en = 4'b1000;
        wait_neg(P * 3);
        check("R6 late enable", status, 0);
        do_read();

        // R7: mask gates irq without touching status
        pins = 4'b0000;
        mask = 1'b0;
        wait_neg(SETTLE);
        check("R7 masked status", status, 1);
        check("R7 masked irq", irq, 0);
        mask = 1'b1;
        #1;
        check("R7 unmasked irq", irq, 1);
        do_read();
        check("R7 irq after clear", irq, 0);

        // R8: change accepted while read is held high is still seen once
        begin
            int fl_cnt = 0;
            int st_cnt = 0;
            @(negedge clk) rd = 1'b1;
            pins = 4'b0100;
            en = 4'b0100;
            for (int c = 0; c < 3 * P + 8; c++) begin
                @(negedge clk);
                if (rdata[6]) fl_cnt++;
                if (status) st_cnt++;
            end
            rd = 1'b0;
            check("R8 flag seen once", fl_cnt, 1);
            check("R8 status seen once", st_cnt, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule